// File: doc/BRIEF.md
# Serial Framed Register Slave

This block lets an external host read and write a byte-wide register space over a byte stream. It sits between a UART byte receiver and a UART byte transmitter, each joined by a valid/ready handshake. It also drives a plain memory port with a write enable toward the register storage. The host sends command frames. Each frame starts with an opcode, then a 16-bit little-endian address, then a length byte, then a write payload when the command is a write. A CRC-16 closes every frame. The block checks the CRC before it acts on the frame. It then answers with a framed acknowledge that carries its own CRC.

Write payload bytes are first collected in an internal staging buffer. They reach the memory port only after the frame CRC has been checked, so a corrupted write leaves the registers untouched. A read drives the memory port one address per response byte. The memory port is read combinationally: `mem_rdata` must follow `mem_addr` in the same cycle.

The controller is one state machine with these states:

| State | Role |
|---|---|
| ST_OPCODE | Idle; waits for an opcode. |
| ST_ADDR_LO, ST_ADDR_HI, ST_LENGTH | Take the header. |
| ST_PAYLOAD | Stages the write payload. |
| ST_CHK_HI, ST_CHK_LO | Take the received CRC. |
| ST_COMMIT | Copies the staged payload to memory, one byte per cycle. |
| ST_RSP_HEAD | Sends the 3 response header bytes. |
| ST_RSP_DATA | Sends the read data. |
| ST_RSP_CHK_HI, ST_RSP_CHK_LO | Send the response CRC. |

Transitions:
- ST_OPCODE moves to ST_ADDR_LO on a known opcode.
- ST_ADDR_LO moves to ST_ADDR_HI, then ST_LENGTH, on each accepted byte.
- ST_LENGTH moves to ST_PAYLOAD for a write and to ST_CHK_HI for a read.
- ST_PAYLOAD moves to ST_CHK_HI on the last payload byte.
- ST_CHK_HI moves to ST_CHK_LO on the next byte.
- ST_CHK_LO moves to ST_COMMIT for a good write, to ST_RSP_HEAD for a good read, and to ST_OPCODE on a CRC mismatch.
- ST_COMMIT moves to ST_RSP_HEAD after the last byte is written.
- ST_RSP_HEAD moves to ST_RSP_DATA, or straight to ST_RSP_CHK_HI when there is no data.
- ST_RSP_DATA moves to ST_RSP_CHK_HI after the last data byte.
- ST_RSP_CHK_HI moves to ST_RSP_CHK_LO, and ST_RSP_CHK_LO returns to ST_OPCODE.
- Every state from ST_ADDR_LO to ST_CHK_LO also returns to ST_OPCODE when the inter-byte gap timer expires.

Top module: `frame_reg_slave`

## Requirements
- R1: A write command is the opcode 0x55, the address low byte, the address high byte, a length byte, the payload, then the CRC. After the CRC passes, byte i of the payload is written to memory address (address + i). The writes happen one per cycle in ascending order.
- R2: A good write is answered with exactly 5 bytes: 0xA5, the address low byte, the address high byte, then the CRC of those 3 bytes.
- R3: A read command is the opcode 0x5A, the address low byte, the address high byte, a length byte, then the CRC, 6 bytes in all. It is answered with 0xAA, the address low byte, the address high byte, the requested bytes in ascending address order, then the CRC over the header and data.
- R4: Every CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, sent high byte first. The command CRC covers the opcode through the last payload byte. The response CRC covers every response byte before it.
- R5: A frame whose CRC does not match is dropped. It causes no memory write and no response, and the block then waits for an opcode.
- R6: In the idle state, a byte other than 0x55 or 0x5A is consumed and ignored.
- R7: A write with length byte 0 carries and stores 256 payload bytes.
- R8: A read with length byte 0 returns no data bytes: the header and the CRC only, 5 bytes in all.
- R9: Once an opcode has been accepted, `gap_bits` pulses of `bit_tick` with no accepted byte return the parser to idle. A `gap_bits` of 0 disables this timeout.
- R10: `rx_ready` is low from the last command byte until the last response byte has been accepted. While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R11: Memory addresses increment modulo 2^16 within a frame.
- R12: After reset, `rx_ready` is 1 and `tx_valid` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can accept a byte |
| tx_valid | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| gap_bits | input | GAP_W | Inter-byte timeout in bit times, 0 = off |
| mem_addr | output | 16 | Register address |
| mem_we | output | 1 | Register write enable |
| mem_wdata | output | 8 | Register write data |
| mem_rdata | input | 8 | Register read data, combinational on mem_addr |

## Verification
The assertions take for granted that the memory port returns data combinationally and that nothing else writes the memory while a response is in flight. They also assume `gap_bits` changes only while the parser is idle. The bench models the storage as a combinational array written only through `mem_we`. It changes `gap_bits` only between frames, after each response has finished or after a dropped frame has settled. The transmitter backpressure pattern is driven independently of the block's state.

// File: rtl/frs_pkg.sv
package frs_pkg;
    localparam int          FRAME_ADDR_W = 16;
    localparam int          LEN_W        = 8;
    localparam logic [7:0]  OP_WRITE     = 8'h55;
    localparam logic [7:0]  OP_READ      = 8'h5A;
    localparam logic [7:0]  ACK_WRITE    = 8'hA5;
    localparam logic [7:0]  ACK_READ     = 8'hAA;

    typedef enum logic [3:0] {
        ST_OPCODE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_LENGTH,
        ST_PAYLOAD,
        ST_CHK_HI,
        ST_CHK_LO,
        ST_COMMIT,
        ST_RSP_HEAD,
        ST_RSP_DATA,
        ST_RSP_CHK_HI,
        ST_RSP_CHK_LO
    } frs_state_e;
endpackage

// File: rtl/frs_crc16.sv
module frs_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    logic [15:0] acc;

    always_comb begin
        acc = crc_in ^ {data_in, 8'h00};
        for (int i = 0; i < 8; i++) begin
            acc = acc[15] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/frs_gap_timer.sv
module frs_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             restart,
    input  logic             bit_tick,
    input  logic [GAP_W-1:0] gap_bits,
    output logic             expired
);
    localparam logic [GAP_W-1:0] ONE = {{(GAP_W-1){1'b0}}, 1'b1};

    logic [GAP_W-1:0] ticks_q;
    logic             enabled;

    assign enabled = (gap_bits != '0);
    assign expired = armed && !restart && enabled && bit_tick && (ticks_q >= gap_bits - ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else if (!armed || restart) begin
            ticks_q <= '0;
        end else if (bit_tick && enabled && !expired) begin
            ticks_q <= ticks_q + ONE;
        end
    end

    // R9: the tick count stays below the limit while a frame is open
    a_r9_ticks_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && enabled && $stable(gap_bits)) |-> (ticks_q < gap_bits));
endmodule

// File: rtl/frs_pbuf.sv
module frs_pbuf #(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata = cells[ridx];
endmodule

// File: rtl/frame_reg_slave.sv
module frame_reg_slave
    import frs_pkg::*;
#(
    parameter int          GAP_W    = 8,
    parameter logic [15:0] CRC_POLY = 16'h1021,
    parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    output logic                    rx_ready,
    output logic                    tx_valid,
    output logic [7:0]              tx_data,
    input  logic                    tx_ready,
    input  logic                    bit_tick,
    input  logic [GAP_W-1:0]        gap_bits,
    output logic [FRAME_ADDR_W-1:0] mem_addr,
    output logic                    mem_we,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata
);
    localparam int PAY_MAX = 1 << LEN_W;
    localparam int CNT_W   = LEN_W + 1;
    localparam int IDX_W   = LEN_W;

    frs_state_e              state_q, state_d;
    logic [FRAME_ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]        len_q;
    logic                    is_wr_q;
    logic [CNT_W-1:0]        cnt_q, cnt_d;
    logic [7:0]              chk_hi_q;
    logic [15:0]             crc_q, crc_step;
    logic [7:0]              crc_byte;
    logic [CNT_W-1:0]        pay_total;
    logic                    rx_fire, tx_fire, gap_expired, crc_ok, crc_take, step_cnt;
    logic                    rx_phase, frame_open;
    logic [7:0]              staged_byte;

    assign rx_fire   = rx_valid && rx_ready;
    assign tx_fire   = tx_valid && tx_ready;
    assign pay_total = (is_wr_q && len_q == '0) ? CNT_W'(PAY_MAX) : {1'b0, len_q};
    assign crc_ok    = ({chk_hi_q, rx_data} == crc_q);
    assign rx_phase  = (state_q inside {ST_OPCODE, ST_ADDR_LO, ST_ADDR_HI, ST_LENGTH,
                                        ST_PAYLOAD, ST_CHK_HI, ST_CHK_LO});
    assign frame_open = rx_phase && (state_q != ST_OPCODE);
    assign crc_byte  = rx_phase ? rx_data : tx_data;

    frs_crc16 #(.POLY(CRC_POLY)) u_crc (
        .crc_in (crc_q),
        .data_in(crc_byte),
        .crc_out(crc_step)
    );

    frs_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (frame_open),
        .restart (rx_fire),
        .bit_tick(bit_tick),
        .gap_bits(gap_bits),
        .expired (gap_expired)
    );

    frs_pbuf #(.DEPTH(PAY_MAX)) u_stage (
        .clk  (clk),
        .we   (state_q == ST_PAYLOAD && rx_fire),
        .widx (cnt_q[IDX_W-1:0]),
        .wdata(rx_data),
        .ridx (cnt_q[IDX_W-1:0]),
        .rdata(staged_byte)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE:   if (rx_fire && (rx_data == OP_WRITE || rx_data == OP_READ)) state_d = ST_ADDR_LO;
            ST_ADDR_LO:  if (rx_fire) state_d = ST_ADDR_HI;
            ST_ADDR_HI:  if (rx_fire) state_d = ST_LENGTH;
            ST_LENGTH:   if (rx_fire) state_d = is_wr_q ? ST_PAYLOAD : ST_CHK_HI;
            ST_PAYLOAD:  if (rx_fire && cnt_q == pay_total - 1'b1) state_d = ST_CHK_HI;
            ST_CHK_HI:   if (rx_fire) state_d = ST_CHK_LO;
            ST_CHK_LO:   if (rx_fire) state_d = !crc_ok ? ST_OPCODE : (is_wr_q ? ST_COMMIT : ST_RSP_HEAD);
            ST_COMMIT:   if (cnt_q == pay_total - 1'b1) state_d = ST_RSP_HEAD;
            ST_RSP_HEAD: if (tx_fire && cnt_q == CNT_W'(2))
                             state_d = (is_wr_q || len_q == '0) ? ST_RSP_CHK_HI : ST_RSP_DATA;
            ST_RSP_DATA: if (tx_fire && cnt_q == pay_total - 1'b1) state_d = ST_RSP_CHK_HI;
            ST_RSP_CHK_HI: if (tx_fire) state_d = ST_RSP_CHK_LO;
            ST_RSP_CHK_LO: if (tx_fire) state_d = ST_OPCODE;
            default:     state_d = ST_OPCODE;
        endcase
        if (frame_open && gap_expired) state_d = ST_OPCODE;
    end

    assign step_cnt = (state_q == ST_PAYLOAD && rx_fire) || (state_q == ST_COMMIT) ||
                      ((state_q == ST_RSP_HEAD || state_q == ST_RSP_DATA) && tx_fire);
    assign cnt_d    = (state_d != state_q) ? '0 : cnt_q + CNT_W'(step_cnt);
    assign crc_take = (rx_phase && rx_fire && state_q != ST_CHK_HI && state_q != ST_CHK_LO) ||
                      ((state_q == ST_RSP_HEAD || state_q == ST_RSP_DATA) && tx_fire);

    // state and context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OPCODE;
            cnt_q    <= '0;
            crc_q    <= CRC_SEED;
            addr_q   <= '0;
            len_q    <= '0;
            is_wr_q  <= 1'b0;
            chk_hi_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_d == ST_OPCODE || (state_d == ST_RSP_HEAD && state_q != ST_RSP_HEAD))
                crc_q <= CRC_SEED;
            else if (crc_take)
                crc_q <= crc_step;
            if (rx_fire) begin
                unique case (state_q)
                    ST_OPCODE:  is_wr_q        <= (rx_data == OP_WRITE);
                    ST_ADDR_LO: addr_q[7:0]    <= rx_data;
                    ST_ADDR_HI: addr_q[15:8]   <= rx_data;
                    ST_LENGTH:  len_q          <= rx_data;
                    ST_CHK_HI:  chk_hi_q       <= rx_data;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        rx_ready  = rx_phase;
        tx_valid  = 1'b0;
        tx_data   = 8'h00;
        mem_we    = (state_q == ST_COMMIT);
        mem_wdata = staged_byte;
        mem_addr  = addr_q + FRAME_ADDR_W'(cnt_q);
        unique case (state_q)
            ST_RSP_HEAD: begin
                tx_valid = 1'b1;
                if (cnt_q == '0)              tx_data = is_wr_q ? ACK_WRITE : ACK_READ;
                else if (cnt_q == CNT_W'(1))  tx_data = addr_q[7:0];
                else                          tx_data = addr_q[15:8];
            end
            ST_RSP_DATA:   begin tx_valid = 1'b1; tx_data = mem_rdata;    end
            ST_RSP_CHK_HI: begin tx_valid = 1'b1; tx_data = crc_q[15:8];  end
            ST_RSP_CHK_LO: begin tx_valid = 1'b1; tx_data = crc_q[7:0];   end
            default: ;
        endcase
    end

    // R1: memory writes begin only right after a checked final CRC byte
    a_r1_write_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(state_q == ST_CHK_LO && rx_fire));
    // R2: the cycle after the last commit write presents the write acknowledge
    a_r2_ack_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> (tx_valid && tx_data == ACK_WRITE));
    // R5: a mismatching CRC byte returns to idle with no response
    a_r5_bad_crc_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHK_LO && rx_fire && !crc_ok) |=> (rx_ready && !tx_valid && !mem_we));
    // R8: a zero-length read skips the data phase
    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RSP_HEAD && tx_fire && cnt_q == CNT_W'(2) && !is_wr_q && len_q == '0)
        |=> (state_q == ST_RSP_CHK_HI));
    // R10: receive side closed while a response byte is offered
    a_r10_rx_closed_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);
    // R10: a stalled response byte holds
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/frame_reg_slave_test.sv
`timescale 1ns/1ps
module frame_reg_slave_test;
    localparam int GAP_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic rx_ready;
    logic tx_valid;
    logic [7:0] tx_data;
    logic tx_ready = 1'b1;
    logic bit_tick = 1'b0;
    logic [GAP_W-1:0] gap_bits = 8'd8;
    logic [15:0] mem_addr;
    logic mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    always #2.5 clk = ~clk;

    frame_reg_slave #(.GAP_W(GAP_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .bit_tick(bit_tick), .gap_bits(gap_bits),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // storage model: combinational read, written only through the port
    logic [7:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    logic [7:0]  shadow [256];
    logic [7:0]  pay [256];
    logic [7:0]  rsp [300];
    logic [7:0]  exp_rsp [300];
    logic [15:0] wr_log [300];
    int rsp_n = 0, exp_n = 0, wr_n = 0, overlap = 0;
    int n_checks = 0, n_err = 0;
    int tick_cnt = 0;
    bit bp_mode = 1'b0;
    bit done = 1'b0;

    // tick, backpressure and response monitor, all away from the active edge
    always @(negedge clk) begin
        tick_cnt = tick_cnt + 1;
        bit_tick = (tick_cnt % 4 == 0);
        tx_ready = bp_mode ? (tick_cnt % 3 != 0) : 1'b1;
        if (tx_valid && rx_ready) overlap = overlap + 1;
        if (tx_valid && tx_ready && rsp_n < 300) begin rsp[rsp_n] = tx_data; rsp_n = rsp_n + 1; end
        if (mem_we && wr_n < 300) begin wr_log[wr_n] = mem_addr; wr_n = wr_n + 1; end
    end

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    // sends a frame; n payload bytes come from pay[]; bad flips the CRC
    task automatic send_frame(input logic [7:0] op, input logic [15:0] a, input logic [7:0] len,
                              input int n, input bit bad);
        logic [15:0] c = 16'hFFFF;
        c = crc_bit(c, op); c = crc_bit(c, a[7:0]); c = crc_bit(c, a[15:8]); c = crc_bit(c, len);
        for (int i = 0; i < n; i++) c = crc_bit(c, pay[i]);
        if (bad) c = c ^ 16'h0100;
        send_byte(op); send_byte(a[7:0]); send_byte(a[15:8]); send_byte(len);
        for (int i = 0; i < n; i++) send_byte(pay[i]);
        send_byte(c[15:8]); send_byte(c[7:0]);
    endtask

    task automatic wait_rsp(input int want);
        for (int i = 0; i < 3000 && rsp_n < want; i++) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_header(input logic [7:0] ack, input logic [15:0] a);
        exp_rsp[0] = ack; exp_rsp[1] = a[7:0]; exp_rsp[2] = a[15:8]; exp_n = 3;
    endtask

    task automatic close_expect();
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < exp_n; i++) c = crc_bit(c, exp_rsp[i]);
        exp_rsp[exp_n] = c[15:8]; exp_rsp[exp_n+1] = c[7:0]; exp_n = exp_n + 2;
    endtask

    task automatic compare_rsp(input string req);
        int bad = -1;
        check(rsp_n == exp_n, req, "response length", rsp_n, exp_n);
        for (int i = 0; i < exp_n && i < rsp_n; i++) if (bad < 0 && rsp[i] !== exp_rsp[i]) bad = i;
        if (bad >= 0) check(1'b0, req, $sformatf("response byte %0d", bad), rsp[bad], exp_rsp[bad]);
        else          check(1'b1, req, "response bytes", 0, 0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] len, input int seed, input string req);
        int n = (len == 0) ? 256 : len;
        for (int i = 0; i < n; i++) pay[i] = 8'((seed * 7 + i * 13 + (i >> 3)) & 8'hFF);
        rsp_n = 0; wr_n = 0;
        send_frame(8'h55, a, len, n, 1'b0);
        expect_header(8'hA5, a); close_expect();
        wait_rsp(exp_n);
        compare_rsp(req);
        for (int i = 0; i < n; i++) shadow[8'(a + 16'(i))] = pay[i];
        check(wr_n == n, req, "write count", wr_n, n);
        check(wr_log[0] == a && wr_log[n-1] == 16'(a + 16'(n - 1)), req, "write span end", wr_log[n-1], 16'(a + 16'(n - 1)));
    endtask

    task automatic do_read(input logic [15:0] a, input logic [7:0] len, input string req);
        rsp_n = 0;
        send_frame(8'h5A, a, len, 0, 1'b0);
        expect_header(8'hAA, a);
        for (int i = 0; i < len; i++) begin exp_rsp[exp_n] = shadow[8'(a + 16'(i))]; exp_n++; end
        close_expect();
        wait_rsp(exp_n);
        compare_rsp(req);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(rx_ready == 1'b1, "R12", "rx_ready after reset", rx_ready, 1);
        check(tx_valid == 1'b0, "R12", "tx_valid after reset", tx_valid, 0);
        check(mem_we == 1'b0,   "R12", "mem_we after reset", mem_we, 0);

        // R1 R2 R3 R4: sweep of write lengths and addresses, each read back
        begin
            int lens [7] = '{1, 2, 3, 5, 16, 100, 255};
            for (int k = 0; k < 7; k++) begin
                logic [15:0] a = 16'(k * 37 + 16'h0300);
                do_write(a, 8'(lens[k]), k + 1, "R1 R2 R4");
                do_read(a, 8'(lens[k]), "R3 R4");
            end
        end

        // R7: zero length write stores 256 bytes
        do_write(16'h0040, 8'd0, 99, "R7");
        do_read(16'h0040, 8'd255, "R7");
        do_read(16'h013F, 8'd1, "R7");

        // R8: zero length read
        do_read(16'h0020, 8'd0, "R8");

        // R11: address wrap
        do_write(16'hFFFE, 8'd4, 5, "R11");
        check(wr_log[2] == 16'h0000 && wr_log[3] == 16'h0001, "R11", "wrapped address", wr_log[2], 0);
        do_read(16'hFFFE, 8'd4, "R11");

        // R5: bad CRC write leaves memory alone and gets no reply
        for (int i = 0; i < 3; i++) pay[i] = 8'hEE;
        rsp_n = 0; wr_n = 0;
        send_frame(8'h55, 16'h0010, 8'd3, 3, 1'b1);
        repeat (60) @(negedge clk);
        check(rsp_n == 0, "R5", "reply to bad write", rsp_n, 0);
        check(wr_n == 0, "R5", "writes from bad frame", wr_n, 0);
        do_read(16'h0010, 8'd3, "R5");
        rsp_n = 0;
        send_frame(8'h5A, 16'h0010, 8'd3, 0, 1'b1);
        repeat (60) @(negedge clk);
        check(rsp_n == 0, "R5", "reply to bad read", rsp_n, 0);

        // R6: stray bytes in idle are ignored
        send_byte(8'h33); send_byte(8'hA5); send_byte(8'h00);
        do_read(16'h0305, 8'd6, "R6");

        // R9: timeout discards a partial frame
        gap_bits = 8'd3;
        send_byte(8'h55); send_byte(8'h20);
        repeat (40) @(negedge clk);
        do_read(16'h0300, 8'd2, "R9");
        // R9: a short gap keeps the frame alive
        gap_bits = 8'd8;
        begin
            logic [15:0] c = 16'hFFFF;
            c = crc_bit(c, 8'h5A); c = crc_bit(c, 8'h01); c = crc_bit(c, 8'h03); c = crc_bit(c, 8'h04);
            rsp_n = 0;
            send_byte(8'h5A); send_byte(8'h01);
            repeat (12) @(negedge clk);
            send_byte(8'h03); send_byte(8'h04); send_byte(c[15:8]); send_byte(c[7:0]);
            expect_header(8'hAA, 16'h0301);
            for (int i = 0; i < 4; i++) begin exp_rsp[exp_n] = shadow[8'(16'h0301 + 16'(i))]; exp_n++; end
            close_expect();
            wait_rsp(exp_n);
            compare_rsp("R9");
            // R9: gap_bits 0 disables the timeout
            gap_bits = 8'd0;
            rsp_n = 0;
            send_byte(8'h5A); send_byte(8'h01);
            repeat (200) @(negedge clk);
            send_byte(8'h03); send_byte(8'h04); send_byte(c[15:8]); send_byte(c[7:0]);
            wait_rsp(exp_n);
            compare_rsp("R9");
            gap_bits = 8'd8;
        end

        // R10: backpressure on the transmitter
        bp_mode = 1'b1;
        do_read(16'h0040, 8'd20, "R10");
        do_write(16'h0080, 8'd9, 17, "R10");
        bp_mode = 1'b0;
        check(overlap == 0, "R10", "rx_ready high during reply", overlap, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule